// File: doc/BRIEF.md
# Cross-Domain Station Address Bank

This block keeps a table of 48-bit station addresses. A host writes and reads the table through a 32-bit word port with byte enables, clocked by the host clock. Address-filter logic that runs on a separate receive/transmit media clock uses the table. Each entry occupies two consecutive word slots. The even slot holds the upper 16 address bits in its low half. The odd slot holds the lower 32 bits.

Host writes land in a staging copy, which is what the host reads back. An entry reaches the media domain only when the host writes one particular byte lane of that entry's low word: the commit lane. At that moment the staged 48-bit value is frozen into a committed copy, and a per-entry toggle flips. A two-flop synchronizer carries the toggle into the media domain. An edge on the synchronized toggle then loads the entry's media-side shadow from the frozen copy. The commit lane depends on a byte-order select input: the top lane for little-endian hosts and the bottom lane for big-endian hosts.

The host must leave at least four media-clock cycles between two commit writes to the same entry. Otherwise a toggle edge can be lost in the synchronizer.

Top module: `addr_xdom_bank`

## Requirements
- R1: On reset, both domains hold every entry at all-ones. A read of an even slot then returns 32'h0000FFFF, a read of an odd slot returns 32'hFFFFFFFF, and the whole media-side output is all-ones.
- R2: Entry e sits at word address 2e (upper half) and 2e+1 (lower half). `h_rdata` shows the staged value of the word addressed in the previous host cycle, one host clock edge after the address is presented.
- R3: `h_be[i]` enables byte i (bits 8i+7:8i) of a write. In an even slot only lanes 0 and 1 are stored, lanes 2 and 3 are dropped, and bits 31:16 of an even-slot read are always zero.
- R4: With `h_big_endian` = 0, a write to an odd slot with `h_be[3]` set commits the entry. Its media-side value equals the full staged 48-bit value after the third media clock edge that follows the host write edge, and still holds the old value after the second.
- R5: With `h_big_endian` = 1, the commit lane is `h_be[0]` instead, with the same latency as R4.
- R6: Writes to an even slot, and odd-slot writes that leave the commit lane disabled, leave the media-side output unchanged. Their bytes are carried over by the next commit write.
- R7: A commit of entry e changes only bits 48e+47:48e of `d_addr`. The upper 16 address bits sit at the top of that slice.
- R8: Word addresses at or above twice the entry count read as zero, and writes to them change neither domain.
- R9: Commit writes to one entry spaced at least four media cycles apart are each delivered, and the last one wins. A closer spacing is flagged as a protocol violation.
- R10: Whenever a media-side entry changes, its new value equals that entry's committed host-side value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host clock |
| h_rst | input | 1 | Host-domain synchronous reset, active high |
| h_wr_en | input | 1 | Write strobe for the current host cycle |
| h_addr | input | ADDR_W | Word address (entry index times two, plus one for the low slot) |
| h_wdata | input | 32 | Write data |
| h_be | input | 4 | Byte enables for the write |
| h_big_endian | input | 1 | Byte-order select: 1 uses lane 0 as commit lane, 0 uses lane 3 |
| h_rdata | output | 32 | Registered read data for the previous cycle's address |
| d_clk | input | 1 | Media-side clock |
| d_rst | input | 1 | Media-domain synchronous reset, active high |
| d_addr | output | NUM_ENTRIES*48 | All shadow entries, entry e in bits 48e+47:48e |

## Verification
Read data is due one host clock edge after the address is driven, so the bench samples it just after that edge. A commit is due at the third media edge after the host write edge: two synchronizer stages plus the shadow load. The bench counts media edges from the recorded write edge. It checks that the old value is still present after the second edge and that the new value is present after the third. The two clocks are phased so that their edges never coincide, which makes this count exact. Non-commit and out-of-range writes are judged after six media edges, well past any possible transfer.

// File: rtl/addr_bank_pkg.sv
`timescale 1ns/1ps
package addr_bank_pkg;

    localparam int BUS_BYTES = 4;
    localparam int STN_W     = 48;
    localparam int HI_W      = 16;
    localparam int LO_W      = 32;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } stn_addr_t;

    localparam stn_addr_t STN_ONES = stn_addr_t'({STN_W{1'b1}});

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

    // byte lane whose write enable commits an entry
    function automatic logic [1:0] commit_lane(byte_order_e order);
        return (order == ORDER_BIG) ? 2'd0 : 2'(BUS_BYTES - 1);
    endfunction

    function automatic logic [LO_W-1:0] lane_merge(logic [LO_W-1:0] old_v,
                                                   logic [31:0] new_v,
                                                   logic [BUS_BYTES-1:0] be);
        logic [LO_W-1:0] res;
        res = old_v;
        for (int b = 0; b < BUS_BYTES; b++) begin
            if (be[b]) res[8*b +: 8] = new_v[8*b +: 8];
        end
        return res;
    endfunction

    function automatic logic [HI_W-1:0] half_merge(logic [HI_W-1:0] old_v,
                                                   logic [31:0] new_v,
                                                   logic [BUS_BYTES-1:0] be);
        logic [HI_W-1:0] res;
        res = old_v;
        for (int b = 0; b < HI_W/8; b++) begin
            if (be[b]) res[8*b +: 8] = new_v[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/addr_bank_host_regs.sv
`timescale 1ns/1ps
module addr_bank_host_regs
    import addr_bank_pkg::*;
#(
    parameter int NUM_ENTRIES = 94,
    parameter int ADDR_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    input  logic [3:0]         be,
    input  byte_order_e        order,
    output logic [31:0]        rdata,
    output stn_addr_t          commit_q [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] tog_q
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    logic             is_low;
    logic             hit;
    logic             commit_en;
    stn_addr_t        stage_w [NUM_ENTRIES];
    logic [31:0]      rd_nxt;

    assign idx       = addr[ADDR_W-1:1];
    assign is_low    = addr[0];
    assign hit       = (int'(idx) < NUM_ENTRIES);
    assign commit_en = be[commit_lane(order)];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic      sel;
        stn_addr_t stage_r;
        stn_addr_t commit_r;
        stn_addr_t stage_nxt;
        logic      tog_r;

        assign sel = wr_en && hit && (idx == IDX_W'(e));

        always_comb begin
            stage_nxt = stage_r;
            if (sel) begin
                if (is_low) stage_nxt.lo = lane_merge(stage_r.lo, wdata, be);
                else        stage_nxt.hi = half_merge(stage_r.hi, wdata, be);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_r  <= STN_ONES;
                commit_r <= STN_ONES;
                tog_r    <= 1'b0;
            end else begin
                stage_r <= stage_nxt;
                if (sel && is_low && commit_en) begin
                    commit_r <= stage_nxt;
                    tog_r    <= ~tog_r;
                end
            end
        end

        assign stage_w[e]  = stage_r;
        assign commit_q[e] = commit_r;
        assign tog_q[e]    = tog_r;
    end

    always_comb begin
        rd_nxt = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (hit && (idx == IDX_W'(e))) begin
                rd_nxt = is_low ? stage_w[e].lo : {16'h0000, stage_w[e].hi};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_nxt;
    end

endmodule

// File: rtl/addr_bank_sync2.sv
`timescale 1ns/1ps
module addr_bank_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/addr_bank_dst_shadow.sv
`timescale 1ns/1ps
module addr_bank_dst_shadow
    import addr_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tog_sync,
    input  stn_addr_t src_in,
    output stn_addr_t shadow_q
);
    logic tog_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_prev <= 1'b0;
            shadow_q <= STN_ONES;
        end else begin
            tog_prev <= tog_sync;
            if (tog_sync != tog_prev) shadow_q <= src_in;
        end
    end

endmodule

// File: rtl/addr_xdom_bank.sv
`timescale 1ns/1ps
module addr_xdom_bank
    import addr_bank_pkg::*;
#(
    parameter int NUM_ENTRIES = 94,
    parameter int ADDR_W      = 8
) (
    input  logic                        h_clk,
    input  logic                        h_rst,
    input  logic                        h_wr_en,
    input  logic [ADDR_W-1:0]           h_addr,
    input  logic [31:0]                 h_wdata,
    input  logic [3:0]                  h_be,
    input  logic                        h_big_endian,
    output logic [31:0]                 h_rdata,
    input  logic                        d_clk,
    input  logic                        d_rst,
    output logic [NUM_ENTRIES*STN_W-1:0] d_addr
);
    stn_addr_t                     commit_w [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]        tog_w;
    logic [NUM_ENTRIES-1:0]        tog_sync;
    logic [NUM_ENTRIES*STN_W-1:0]  commit_flat;

    addr_bank_host_regs #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W)
    ) host_i (
        .clk      (h_clk),
        .rst      (h_rst),
        .wr_en    (h_wr_en),
        .addr     (h_addr),
        .wdata    (h_wdata),
        .be       (h_be),
        .order    (byte_order_e'(h_big_endian)),
        .rdata    (h_rdata),
        .commit_q (commit_w),
        .tog_q    (tog_w)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_xfer
        stn_addr_t shadow_w;

        addr_bank_sync2 #(.W(1)) sync_i (
            .clk (d_clk),
            .rst (d_rst),
            .d   (tog_w[e]),
            .q   (tog_sync[e])
        );

        addr_bank_dst_shadow shadow_i (
            .clk      (d_clk),
            .rst      (d_rst),
            .tog_sync (tog_sync[e]),
            .src_in   (commit_w[e]),
            .shadow_q (shadow_w)
        );

        assign commit_flat[e*STN_W +: STN_W] = commit_w[e];
        assign d_addr[e*STN_W +: STN_W]      = shadow_w;
    end

endmodule

// File: rtl/addr_bank_chk.sv
`timescale 1ns/1ps
module addr_bank_chk #(
    parameter int NUM_ENTRIES = 94,
    parameter int ADDR_W      = 8
) (
    input logic                         h_clk,
    input logic                         h_rst,
    input logic                         h_wr_en,
    input logic [ADDR_W-1:0]            h_addr,
    input logic [3:0]                   h_be,
    input logic                         h_big_endian,
    input logic [31:0]                  h_rdata,
    input logic                         d_clk,
    input logic                         d_rst,
    input logic [NUM_ENTRIES*48-1:0]    d_addr,
    input logic [NUM_ENTRIES*48-1:0]    commit_flat,
    input logic [NUM_ENTRIES-1:0]       tog_w
);
    localparam int MIN_GAP = 4;

    initial begin
        // R8
        cfg_fit_chk: assert (2 * NUM_ENTRIES <= (1 << ADDR_W));
    end

    logic [31:0] dcnt;
    always_ff @(posedge d_clk) begin
        if (d_rst) dcnt <= '0;
        else       dcnt <= dcnt + 32'd1;
    end

    // R1
    rst_shadow_chk: assert property (@(posedge d_clk) disable iff (d_rst)
        $past(d_rst) |-> (d_addr == {NUM_ENTRIES*48{1'b1}}));

    // R3
    hi_zero_chk: assert property (@(posedge h_clk) disable iff (h_rst)
        $past(h_addr[0] == 1'b0) |-> (h_rdata[31:16] == 16'h0000));

    // R8
    oob_read_chk: assert property (@(posedge h_clk) disable iff (h_rst)
        $past(int'(h_addr) >= 2 * NUM_ENTRIES) |-> (h_rdata == 32'h0));

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
        logic        tprev;
        logic        seen;
        logic [31:0] stamp;

        always_ff @(posedge h_clk) begin
            if (h_rst) begin
                tprev <= 1'b0;
                seen  <= 1'b0;
                stamp <= '0;
            end else begin
                tprev <= tog_w[e];
                if (tog_w[e] != tprev) begin
                    seen  <= 1'b1;
                    stamp <= dcnt;
                end
            end
        end

        // R4 R5
        commit_cause_chk: assert property (@(posedge h_clk) disable iff (h_rst)
            !$stable(tog_w[e]) |->
                $past(h_wr_en && (h_addr == ADDR_W'(2 * e + 1)) &&
                      (h_big_endian ? h_be[0] : h_be[3])));

        // R9
        commit_gap_chk: assert property (@(posedge h_clk) disable iff (h_rst)
            ((tog_w[e] != tprev) && seen) |-> ((dcnt - stamp) >= 32'(MIN_GAP)));

        // R10
        shadow_src_chk: assert property (@(posedge d_clk) disable iff (d_rst)
            !$stable(d_addr[e*48 +: 48]) |-> (d_addr[e*48 +: 48] == commit_flat[e*48 +: 48]));
    end

endmodule

bind addr_xdom_bank addr_bank_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W)
) chk_i (
    .h_clk        (h_clk),
    .h_rst        (h_rst),
    .h_wr_en      (h_wr_en),
    .h_addr       (h_addr),
    .h_be         (h_be),
    .h_big_endian (h_big_endian),
    .h_rdata      (h_rdata),
    .d_clk        (d_clk),
    .d_rst        (d_rst),
    .d_addr       (d_addr),
    .commit_flat  (commit_flat),
    .tog_w        (tog_w)
);

// File: tb/addr_xdom_bank_tb_top.sv
`timescale 1ns/1ps
module addr_xdom_bank_tb_top;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int FW = N * 48;

    logic          h_clk = 1'b0;
    logic          d_clk = 1'b0;
    logic          h_rst = 1'b1;
    logic          d_rst = 1'b1;
    logic          h_wr_en = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [31:0]   h_wdata = '0;
    logic [3:0]    h_be = '0;
    logic          h_big_endian = 1'b0;
    logic [31:0]   h_rdata;
    logic [FW-1:0] d_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int dcyc   = 0;
    int mark   = 0;
    logic [47:0] m_stage  [N];
    logic [47:0] m_commit [N];

    addr_xdom_bank #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut_i (
        .h_clk        (h_clk),
        .h_rst        (h_rst),
        .h_wr_en      (h_wr_en),
        .h_addr       (h_addr),
        .h_wdata      (h_wdata),
        .h_be         (h_be),
        .h_big_endian (h_big_endian),
        .h_rdata      (h_rdata),
        .d_clk        (d_clk),
        .d_rst        (d_rst),
        .d_addr       (d_addr)
    );

    always #5 h_clk = ~h_clk;
    initial begin
        #1.3;
        forever #3.65 d_clk = ~d_clk;
    end
    always @(posedge d_clk) dcyc++;

    task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] exp_flat();
        logic [FW-1:0] v;
        for (int e = 0; e < N; e++) v[e*48 +: 48] = m_commit[e];
        return v;
    endfunction

    task automatic model_write(int a, logic [31:0] d, logic [3:0] be);
        int e;
        if (a < 2 * N) begin
            e = a / 2;
            if (a % 2 == 1) begin
                for (int b = 0; b < 4; b++) if (be[b]) m_stage[e][8*b +: 8] = d[8*b +: 8];
                if (be[h_big_endian ? 0 : 3]) m_commit[e] = m_stage[e];
            end else begin
                for (int b = 0; b < 2; b++) if (be[b]) m_stage[e][32 + 8*b +: 8] = d[8*b +: 8];
            end
        end
    endtask

    task automatic hwrite(int a, logic [31:0] d, logic [3:0] be);
        @(negedge h_clk);
        h_wr_en = 1'b1;
        h_addr  = AW'(a);
        h_wdata = d;
        h_be    = be;
        @(posedge h_clk);
        mark = dcyc;
        model_write(a, d, be);
        @(negedge h_clk);
        h_wr_en = 1'b0;
        h_be    = 4'h0;
    endtask

    task automatic hread(int a, output logic [31:0] v);
        @(negedge h_clk);
        h_addr = AW'(a);
        @(posedge h_clk);
        #1;
        v = h_rdata;
    endtask

    task automatic wait_d(int n);
        wait (dcyc >= mark + n);
        #1;
    endtask

    function automatic logic [31:0] exp_word(int a);
        if (a >= 2 * N) return 32'h0;
        if (a % 2 == 1) return m_stage[a/2][31:0];
        return {16'h0000, m_stage[a/2][47:32]};
    endfunction

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [47:0] old_v;
        logic [15:0] hi;
        logic [31:0] lo;
        logic [3:0]  be_part;
        logic [3:0]  be_trig;

        for (int e = 0; e < N; e++) begin
            m_stage[e]  = '1;
            m_commit[e] = '1;
        end
        repeat (6) @(negedge h_clk);
        h_rst = 1'b0;
        @(negedge d_clk);
        d_rst = 1'b0;
        repeat (3) @(negedge h_clk);

        // R1: reset contents in both domains
        for (int a = 0; a < 2 * N; a++) begin
            hread(a, rv);
            chk("R1 reset read", FW'(rv), FW'((a % 2 == 1) ? 32'hFFFFFFFF : 32'h0000FFFF));
        end
        chk("R1 reset shadow", d_addr, {FW{1'b1}});

        // R8: out-of-range slots
        for (int a = 2 * N; a < (1 << AW); a++) begin
            hread(a, rv);
            chk("R8 oob read", FW'(rv), '0);
        end
        hwrite(2 * N, 32'h11223344, 4'hF);
        hwrite(2 * N + 1, 32'h55667788, 4'hF);
        hwrite((1 << AW) - 1, 32'h99AABBCC, 4'hF);
        wait_d(6);
        chk("R8 oob write shadow", d_addr, exp_flat());
        for (int a = 0; a < 2 * N; a++) begin
            hread(a, rv);
            chk("R8 oob write read", FW'(rv), FW'(exp_word(a)));
        end

        // sweep: both byte orders, every entry
        for (int mode = 0; mode < 2; mode++) begin
            h_big_endian = mode[0];
            be_part = mode[0] ? 4'b1110 : 4'b0111;
            be_trig = mode[0] ? 4'b0001 : 4'b1000;
            for (int e = 0; e < N; e++) begin
                hi = 16'h1000 * 16'(e + 1) + 16'h0101 * 16'(mode);
                lo = 32'h0F1E2D3C + 32'h01010101 * 32'(e) + 32'h10000000 * 32'(mode);

                // R3: upper lanes of the even slot dropped
                hwrite(2 * e, {16'hBEEF, hi}, 4'hF);
                hread(2 * e, rv);
                chk("R3 high slot read", FW'(rv), FW'({16'h0000, hi}));

                // R6: non-commit lanes stay on the host side
                hwrite(2 * e + 1, lo, be_part);
                wait_d(6);
                chk("R6 no transfer", d_addr, exp_flat());
                hread(2 * e + 1, rv);
                chk("R2 low slot read", FW'(rv), FW'(exp_word(2 * e + 1)));

                // R4 / R5: commit lane and exact latency
                old_v = m_commit[e];
                hwrite(2 * e + 1, lo, be_trig);
                wait_d(2);
                chk(mode[0] ? "R5 old value at edge 2" : "R4 old value at edge 2",
                    FW'(d_addr[e*48 +: 48]), FW'(old_v));
                wait_d(3);
                chk(mode[0] ? "R5 commit at edge 3" : "R4 commit at edge 3",
                    FW'(d_addr[e*48 +: 48]), FW'({hi, lo}));
                // R7: other entries untouched
                chk("R7 entry isolation", d_addr, exp_flat());
            end
        end

        // R3: partial high write, lane 2 ignored
        h_big_endian = 1'b0;
        hwrite(6, 32'h12345678, 4'b0110);
        hread(6, rv);
        chk("R3 partial high", FW'(rv), FW'(exp_word(6)));
        hwrite(7, 32'hCAFEF00D, 4'b1000);
        wait_d(4);
        chk("R3 partial high commit", d_addr, exp_flat());

        // R9: two commits at the minimum spacing, last wins
        hwrite(5, 32'hA5A5A5A5, 4'hF);
        wait_d(4);
        hwrite(5, 32'h5A5A5A5A, 4'hF);
        wait_d(3);
        chk("R9 spaced commits", d_addr, exp_flat());
        chk("R9 last value", FW'(d_addr[2*48 +: 32]), FW'(32'h5A5A5A5A));

        // R10: shadow follows committed copy after big-endian commit
        h_big_endian = 1'b1;
        hwrite(0, 32'h0000ABCD, 4'h3);
        hwrite(1, 32'h76543210, 4'h1);
        wait_d(3);
        chk("R10 shadow equals commit", d_addr, exp_flat());

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule